// File: doc/BRIEF.md
# Keyboard link protocol engine

This block sits on the keyboard side of a half-duplex byte link to a host. It sends each key press and release as two bytes, a row byte and then a column byte, and it waits for a separate acknowledge from the host after each byte. The type of the acknowledge that closes a packet sets two modes for the packets that follow. One mode turns key scanning on or off. The other turns unsolicited mouse reports on or off. A reset handshake brings the link up after power-on. The same handshake runs after a user reset and after any protocol error. During the handshake the block keeps sending its reset code until the host returns that code.

The block also watches two mouse axes. Each axis has a reference line and a direction line, and each is decoded into a signed 7-bit movement count. The block sends these counts as two-byte mouse reports. A report goes out when the host asks for one, or when mouse reporting is on and a count is nonzero. When either count reaches its limit, both counts freeze and the mouse report jumps ahead of pending key data. The mouse buttons are sent as key events and follow the same scan gating. Matrix scanning, debouncing and serial framing are handled outside the block. The external scanner reads `scan_en`. When scanning turns back on, it restarts from an all-released image, so keys still held are reported again as new key-downs.

Top module: `kbd_link_engine`

## Requirements
- R1: Reset code 0xFF is sent in three cases: after power-on, after `user_reset`, and after a protocol error. Each host reply other than 0xFF causes 0xFF to be sent again. A 0xFF reply returns the block to idle with scanning and mouse reporting both off.
- R2: No new byte is offered (`tx_valid` low) between the acceptance of a byte (`tx_valid && tx_ready`) and the next host byte. While `tx_ready` is low, `tx_data` holds steady.
- R3: A key event is sent as a row byte followed by a column byte. The upper nibble of each byte is 0xC for key-down and 0xD for key-up. The lower nibble holds the row or column address.
- R4: The first byte of a packet must be answered with 0x3F. The second byte must be answered with a final code from 0x30 to 0x33. Any other reply starts R1. A 0xFF from the host outside the reset handshake restarts at once. In idle, host bytes other than 0xFF and 0x22 are ignored.
- R5: The final code sets the modes. 0x30 turns scanning and mouse reporting off. 0x31 turns scanning on only. 0x32 turns mouse reporting on only. 0x33 turns both on. `scan_en` shows the scan mode.
- R6: Key events that arrive while scanning is off are dropped (`key_ready` is high and nothing is sent). With scanning on, one event can be held, and `key_ready` stays low while an event is held.
- R7: Button i is sent as row 7, column i: 0xC7 then 0xC0+i when pressed, 0xD7 then 0xD0+i when released. Buttons follow the scan gating. A button still held when scanning resumes is sent as a new key-down. A held button is not repeated.
- R8: Each axis takes {ref,dir}. The sequence 00, 01, 11, 10 counts up, the reverse sequence counts down, and a change of both bits at once is ignored.
- R9: A mouse report is the X byte followed by the Y byte. Each is the 7-bit two's-complement count sign-extended to 8 bits. Both counts are copied and cleared when the report starts, so each report covers movement since the previous report. Reports follow the acknowledge rules of R4.
- R10: When either count reaches +63 or -64, both counts ignore further movement until a report starts.
- R11: When the counts are frozen and a report is allowed, the mouse report goes ahead of a held key event. In every other case the key event goes first.
- R12: A report is sent unprompted when mouse reporting is on and a count is nonzero. A request 0x22 forces a report even when both counts are zero. A request that arrives during a packet is held until that packet ends. Repeated requests get one report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_reset | input | 1 | One-cycle pulse that restarts the link |
| rx_valid | input | 1 | Host byte strobe, one cycle |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Byte offered to the link |
| tx_data | output | 8 | Byte offered |
| tx_ready | input | 1 | Link takes the byte this cycle |
| key_valid | input | 1 | Key event offered by the scanner |
| key_down | input | 1 | 1 = press, 0 = release |
| key_row | input | 4 | Matrix row of the event |
| key_col | input | 4 | Matrix column of the event |
| key_ready | output | 1 | Event taken (or dropped while scanning is off) |
| btn | input | 3 | Debounced mouse button levels, 1 = pressed |
| x_ref | input | 1 | X axis reference line |
| x_dir | input | 1 | X axis direction line |
| y_ref | input | 1 | Y axis reference line |
| y_dir | input | 1 | Y axis direction line |
| scan_en | output | 1 | Key scanning enabled |

## Verification
The assertions assume three things about the inputs. Host bytes arrive as single-cycle strobes. The link raises `tx_ready` only while a byte is offered. The quadrature lines move through at most one valid state per sampling window, apart from deliberate double-bit jumps. The stimulus changes inputs only on falling clock edges. It raises `tx_ready` for one cycle per expected byte and otherwise keeps it low, so bytes are never taken unobserved. Each quadrature step is held for four cycles, so the two-stage synchroniser and the edge detector see every step. Jumps are produced only by the task written to flip both lines of an axis together.

// File: rtl/kbd_link_engine.sv
`timescale 1ns/1ps
module kbd_link_engine #(
  parameter logic [7:0] C_RESET  = 8'hFF,
  parameter logic [7:0] C_BYTEOK = 8'h3F,
  parameter logic [7:0] C_NONE   = 8'h30,
  parameter logic [7:0] C_SCAN   = 8'h31,
  parameter logic [7:0] C_MOUSE  = 8'h32,
  parameter logic [7:0] C_BOTH   = 8'h33,
  parameter logic [7:0] C_MREQ   = 8'h22,
  parameter int CW = 7,
  parameter int NBTN = 3,
  parameter logic [3:0] BTN_ROW = 4'h7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            user_reset,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  input  logic            tx_ready,
  input  logic            key_valid,
  input  logic            key_down,
  input  logic [3:0]      key_row,
  input  logic [3:0]      key_col,
  output logic            key_ready,
  input  logic [NBTN-1:0] btn,
  input  logic            x_ref,
  input  logic            x_dir,
  input  logic            y_ref,
  input  logic            y_dir,
  output logic            scan_en
);
  localparam logic [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};

  typedef enum logic [2:0] {RSEND, RWAIT, IDLE, B1, W1, B2, W2} st_t;
  st_t state;

  logic mouse_en, mreq, pend_v, pkt_m;
  logic [8:0] pend;
  logic [7:0] b1, b2;
  logic [NBTN-1:0] btn_seen, bsel;
  logic [3:0] bidx;
  logic bany;
  logic [2*CW-1:0] cnt;
  logic [CW-1:0] cx, cy;

  assign cx = cnt[CW-1:0];
  assign cy = cnt[2*CW-1:CW];

  wire rx_rst = rx_valid && rx_data == C_RESET;
  wire rx_req = rx_valid && rx_data == C_MREQ;
  wire rx_fin = rx_valid && (rx_data == C_NONE || rx_data == C_SCAN ||
                             rx_data == C_MOUSE || rx_data == C_BOTH);
  wire in_pkt = state != RSEND && state != RWAIT;
  wire bad1 = state == W1 && rx_valid && !rx_rst && !rx_req && rx_data != C_BYTEOK;
  wire bad2 = state == W2 && rx_valid && !rx_rst && !rx_req && !rx_fin;
  wire restart = user_reset || (in_pkt && rx_rst) || bad1 || bad2;

  wire locked = cx == CMAX || cx == CMIN || cy == CMAX || cy == CMIN;
  wire moved  = |cnt;
  wire want_key = pend_v && scan_en;
  wire want_m   = mreq || (mouse_en && moved);
  wire start_m  = state == IDLE && !restart &&
                  ((locked && (mouse_en || mreq)) || (!want_key && want_m));
  wire start_k  = state == IDLE && !restart && !start_m && want_key;
  wire mclr     = start_m || restart;

  assign key_ready = !scan_en || !pend_v;
  assign tx_valid  = state == RSEND || state == B1 || state == B2;

  always_comb begin
    case (state)
      RSEND:   tx_data = C_RESET;
      B1:      tx_data = b1;
      B2:      tx_data = b2;
      default: tx_data = 8'h00;
    endcase
  end

  always_comb begin
    bany = 1'b0;
    bidx = 4'd0;
    bsel = '0;
    for (int i = NBTN - 1; i >= 0; i--) begin
      if (btn[i] != btn_seen[i]) begin
        bany = 1'b1;
        bidx = i[3:0];
        bsel = '0;
        bsel[i] = 1'b1;
      end
    end
  end

  function automatic logic [1:0] qdec(input logic [1:0] o, input logic [1:0] n);
    if (n == {o[0], ~o[1]})      return 2'b11;
    else if (n == {~o[0], o[1]}) return 2'b10;
    else                         return 2'b00;
  endfunction

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [1:0] s1, s2, sp, qin, st;
    logic [CW-1:0] c;
    assign qin = (a == 0) ? {x_ref, x_dir} : {y_ref, y_dir};
    assign st  = qdec(sp, s2);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 2'b00; s2 <= 2'b00; sp <= 2'b00; c <= '0;
      end else begin
        s1 <= qin;
        s2 <= s1;
        sp <= s2;
        if (mclr) c <= '0;
        else if (!locked && st[1]) c <= st[0] ? c + 1'b1 : c - 1'b1;
      end
    end
    assign cnt[a*CW +: CW] = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RSEND;
      scan_en <= 1'b0; mouse_en <= 1'b0; mreq <= 1'b0;
      pend_v <= 1'b0; pend <= '0; btn_seen <= '0;
      b1 <= '0; b2 <= '0; pkt_m <= 1'b0;
    end else if (restart) begin
      state <= RSEND;
      scan_en <= 1'b0; mouse_en <= 1'b0; mreq <= 1'b0;
      pend_v <= 1'b0; btn_seen <= '0;
    end else begin
      if (start_m) mreq <= 1'b0;
      else if (rx_req && in_pkt) mreq <= 1'b1;

      if (!scan_en) begin
        pend_v <= 1'b0;
        btn_seen <= '0;
      end else if (start_k) begin
        pend_v <= 1'b0;
      end else if (!pend_v) begin
        if (key_valid) begin
          pend_v <= 1'b1;
          pend <= {key_down, key_row, key_col};
        end else if (bany) begin
          pend_v <= 1'b1;
          pend <= {|(btn & bsel), BTN_ROW, bidx};
          btn_seen <= (btn_seen & ~bsel) | (btn & bsel);
        end
      end

      case (state)
        RSEND: if (tx_ready) state <= RWAIT;
        RWAIT: if (rx_valid) state <= rx_rst ? IDLE : RSEND;
        IDLE: begin
          if (start_m) begin
            b1 <= {{(8-CW){cx[CW-1]}}, cx};
            b2 <= {{(8-CW){cy[CW-1]}}, cy};
            pkt_m <= 1'b1;
            state <= B1;
          end else if (start_k) begin
            b1 <= {pend[8] ? 4'hC : 4'hD, pend[7:4]};
            b2 <= {pend[8] ? 4'hC : 4'hD, pend[3:0]};
            pkt_m <= 1'b0;
            state <= B1;
          end
        end
        B1: if (tx_ready) state <= W1;
        W1: if (rx_valid && rx_data == C_BYTEOK) state <= B2;
        B2: if (tx_ready) state <= W2;
        W2: if (rx_fin) begin
          state <= IDLE;
          scan_en  <= rx_data == C_SCAN  || rx_data == C_BOTH;
          mouse_en <= rx_data == C_MOUSE || rx_data == C_BOTH;
        end
        default: state <= RSEND;
      endcase
    end
  end

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !user_reset && !rx_valid |=> tx_valid && $stable(tx_data));

  // R2
  tx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !user_reset && !rx_valid |=> !tx_valid);

  // R3
  key_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && state != RSEND && !pkt_m |-> tx_data[7:4] == 4'hC || tx_data[7:4] == 4'hD);

  // R5
  scan_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> $past(rx_valid));

  // R10
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !mclr |=> $stable(cx) && $stable(cy));
endmodule

// File: tb/kbd_link_engine_tb.sv
`timescale 1ns/1ps
module kbd_link_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, user_reset = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, key_ready, scan_en;
  logic [7:0] tx_data;
  logic key_valid = 1'b0, key_down = 1'b0;
  logic [3:0] key_row = 4'h0, key_col = 4'h0;
  logic [2:0] btn = 3'b000;
  logic x_ref = 1'b0, x_dir = 1'b0, y_ref = 1'b0, y_dir = 1'b0;

  kbd_link_engine dut_i (
    .clk(clk), .rst_n(rst_n), .user_reset(user_reset),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .key_valid(key_valid), .key_down(key_down), .key_row(key_row), .key_col(key_col),
    .key_ready(key_ready), .btn(btn),
    .x_ref(x_ref), .x_dir(x_dir), .y_ref(y_ref), .y_dir(y_dir),
    .scan_en(scan_en));

  int vectors = 0, fails = 0;
  bit waiting = 0, scan_model = 0, done = 0;
  int mx = 0, my = 0, xi = 0, yi = 0;

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      vectors++;
      if (scan_en !== scan_model) begin
        fails++;
        $display("FAIL R5: scan_en=%0b expected %0b", scan_en, scan_model);
      end
      vectors++;
      if (waiting && tx_valid) begin
        fails++;
        $display("FAIL R2: tx_valid=1 while awaiting host byte, expected 0 (data %h)", tx_data);
      end
    end
  end

  function automatic logic [1:0] qseq(input int i);
    case (i)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic bit mlock();
    return mx == 63 || mx == -64 || my == 63 || my == -64;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic expect_byte(input logic [7:0] e, input string rq, input int stall = 0);
    int n = 0;
    while (!tx_valid && n < 3000) begin @(negedge clk); n++; end
    vectors++;
    if (!tx_valid || tx_data !== e) begin
      fails++;
      $display("FAIL %s: tx byte valid=%0b data=%h expected %h", rq, tx_valid, tx_data, e);
    end
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      vectors++;
      if (!tx_valid || tx_data !== e) begin
        fails++;
        $display("FAIL R2: stalled byte valid=%0b data=%h expected %h", tx_valid, tx_data, e);
      end
    end
    tx_ready = 1'b1;
    @(posedge clk);
    waiting = 1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic reply(input logic [7:0] b, input int s);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk);
    waiting = 0;
    if (s >= 0) scan_model = s[0];
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic quiet(input int n, input string rq);
    bit bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tx_valid) bad = 1;
    end
    vectors++;
    if (bad) begin
      fails++;
      $display("FAIL %s: tx_valid=1 seen, expected link quiet", rq);
    end
  endtask

  task automatic key(input bit dn, input logic [3:0] r, input logic [3:0] c);
    int n = 0;
    key_valid = 1'b1; key_down = dn; key_row = r; key_col = c;
    while (!key_ready && n < 3000) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic step(input int axis, input int dir);
    if (axis == 0) begin xi = (xi + dir + 4) % 4; {x_ref, x_dir} = qseq(xi); end
    else begin yi = (yi + dir + 4) % 4; {y_ref, y_dir} = qseq(yi); end
    if (!mlock()) begin
      if (axis == 0) mx += dir; else my += dir;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic jump_x();
    xi = (xi + 2) % 4;
    {x_ref, x_dir} = qseq(xi);
    repeat (4) @(negedge clk);
  endtask

  task automatic mouse_pkt(input logic [7:0] fin, input int s, input string rq);
    logic [7:0] ex, ey;
    ex = 8'(mx); ey = 8'(my);
    expect_byte(ex, rq);
    mx = 0; my = 0;
    reply(8'h3F, -1);
    expect_byte(ey, rq);
    reply(fin, s);
  endtask

  task automatic key_pkt(input logic [7:0] a, input logic [7:0] b, input logic [7:0] fin,
                         input int s, input string rq);
    expect_byte(a, rq);
    reply(8'h3F, -1);
    expect_byte(b, rq);
    reply(fin, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1: watchdog expired, run still active, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    vectors++;
    if (tx_valid !== 1'b1 || tx_data !== 8'hFF || scan_en !== 1'b0 || key_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: reset state valid=%0b data=%h scan=%0b kr=%0b expected 1 ff 0 1",
               tx_valid, tx_data, scan_en, key_ready);
    end
    // R1 handshake with a bad reply
    expect_byte(8'hFF, "R1");
    reply(8'h55, 0);
    expect_byte(8'hFF, "R1");
    reply(8'hFF, 0);
    quiet(20, "R1");
    // R4 idle bytes ignored
    reply(8'h31, 0);
    quiet(20, "R4");
    // R6 key ignored while scanning off
    key(1, 4'h2, 4'h2);
    quiet(20, "R6");
    // R12 request with zero counts, R5 scan-only
    reply(8'h22, -1);
    mouse_pkt(8'h31, 1, "R12");
    quiet(20, "R6");
    // R3 key events, R6 holding, R2 stall
    key(1, 4'h3, 4'h5);
    expect_byte(8'hC3, "R3");
    reply(8'h3F, -1);
    expect_byte(8'hC5, "R3");
    key(0, 4'h3, 4'h5);
    vectors++;
    if (key_ready !== 1'b0) begin
      fails++;
      $display("FAIL R6: key_ready=%0b with event held, expected 0", key_ready);
    end
    reply(8'h31, 1);
    expect_byte(8'hD3, "R3", 5);
    reply(8'h3F, -1);
    expect_byte(8'hD5, "R3");
    reply(8'h31, 1);
    // R7 buttons
    btn = 3'b010;
    key_pkt(8'hC7, 8'hC1, 8'h31, 1, "R7");
    quiet(40, "R7");
    reply(8'h22, -1);
    mouse_pkt(8'h30, 0, "R5");
    quiet(20, "R7");
    reply(8'h22, -1);
    mouse_pkt(8'h31, 1, "R5");
    key_pkt(8'hC7, 8'hC1, 8'h31, 1, "R7");
    btn = 3'b000;
    key_pkt(8'hD7, 8'hD1, 8'h31, 1, "R7");
    // R8 quadrature, R9 reports
    for (int k = 0; k < 5; k++) step(0, 1);
    jump_x();
    jump_x();
    for (int k = 0; k < 3; k++) step(1, -1);
    quiet(10, "R12");
    reply(8'h22, -1);
    mouse_pkt(8'h31, 1, "R8");
    reply(8'h22, -1);
    mouse_pkt(8'h30, 0, "R9");
    // R4 bad first ack
    reply(8'h22, -1);
    expect_byte(8'h00, "R9");
    reply(8'h31, 0);
    expect_byte(8'hFF, "R4");
    reply(8'hFF, 0);
    // R4 bad final ack
    reply(8'h22, -1);
    expect_byte(8'h00, "R9");
    reply(8'h3F, -1);
    expect_byte(8'h00, "R9");
    reply(8'h3F, 0);
    expect_byte(8'hFF, "R4");
    reply(8'hFF, 0);
    // R12 unsolicited report in mouse-only mode
    reply(8'h22, -1);
    mouse_pkt(8'h32, 0, "R5");
    step(0, 1);
    mouse_pkt(8'h32, 0, "R12");
    quiet(30, "R12");
    // R12 request held mid-packet and answered once
    reply(8'h22, -1);
    expect_byte(8'h00, "R12");
    reply(8'h3F, -1);
    expect_byte(8'h00, "R12");
    reply(8'h22, -1);
    reply(8'h22, -1);
    reply(8'h33, 1);
    mouse_pkt(8'h33, 1, "R12");
    quiet(30, "R12");
    // R10 lock and R11 priority
    key(1, 4'h2, 4'h1);
    expect_byte(8'hC2, "R3");
    reply(8'h3F, -1);
    expect_byte(8'hC1, "R3");
    for (int k = 0; k < 70; k++) step(0, 1);
    step(1, 1);
    step(1, 1);
    key(1, 4'h4, 4'h6);
    reply(8'h33, 1);
    mouse_pkt(8'h33, 1, "R10");
    expect_byte(8'hC4, "R11");
    reply(8'h3F, -1);
    expect_byte(8'hC6, "R11");
    step(0, 1);
    step(0, 1);
    key(1, 4'h5, 4'h5);
    reply(8'h33, 1);
    key_pkt(8'hC5, 8'hC5, 8'h33, 1, "R11");
    mouse_pkt(8'h30, 0, "R11");
    // R1 user reset
    user_reset = 1'b1;
    waiting = 0;
    @(posedge clk);
    scan_model = 0;
    @(negedge clk);
    user_reset = 1'b0;
    expect_byte(8'hFF, "R1");
    reply(8'hFF, 0);
    // R4 host reset mid-packet
    reply(8'h22, -1);
    expect_byte(8'h00, "R9");
    reply(8'hFF, 0);
    expect_byte(8'hFF, "R4");
    reply(8'hFF, 0);
    quiet(20, "R1");
    finish_run();
  end
endmodule